// File: doc/BRIEF.md
# Delay-Line Lock Controller

This block is the digital control loop of a multiphase delay-locked loop built from eight identical delay blocks. The phase of the eighth block is compared with the reference clock by a windowed phase detector made of two flip-flops. Once per reference cycle the controller receives the two sampled detector bits, together with a strobe that marks them as fresh. From these it computes the delay control word that all eight blocks share. The low field of the word sets the fine delay and is also output as a thermometer code, so that adjacent settings differ in exactly one enable line.

After reset the controller first waits for an external harmonic check to pass, so that it never locks onto two reference periods. It then finds the delay quickly with a successive-approximation search over the lower half of the range, decided bit by bit from the top. It reports lock and then moves to a closed-loop tracking mode that nudges the word by one step at a time, so that slow drift is followed.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While `rst` is high, at every clock edge `code` becomes 0, `state` becomes 0, and `locked` and `therm` read 0.
- R2: `state` encodes the stage as 0 = harmonic check, 1 = search, 2 = lock and 3 = tracking. The only forward path is 0 to 1 to 2 to 3, and all transitions happen on an update (`upd` high at a clock edge).
- R3: In stage 0, an update with `harmonic_ok` high enters search with only bit CW-2 of `code` set. An update with `harmonic_ok` low leaves the stage and `code` (zero) unchanged.
- R4: In search, the detector pair {q1,q2} = 00 (reference late, more delay needed) or 01 (inside window) keeps the bit under test, and 11 clears it. The next lower bit is then set as the new trial. After bit 0 has been decided, the stage becomes lock. Bit CW-1 stays 0 throughout.
- R5: The pair {q1,q2} = 10 is invalid. An update carrying it changes neither `code` nor `state`, in any stage.
- R6: In lock, the next update moves to tracking and leaves `code` unchanged.
- R7: In tracking, 00 adds 1 to `code`, 11 subtracts 1, and 01 holds it.
- R8: In tracking, `code` saturates at all-ones on increments and at zero on decrements, and never wraps.
- R9: `locked` is high exactly when `state` is 2 or 3.
- R10: `therm` bit i is 1 exactly when the fine field `code[FW-1:0]` is greater than i.
- R11: A clock edge with `upd` low changes neither `code` nor `state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Strobe: detector bits are fresh for this reference cycle |
| q1 | input | 1 | First detector flip-flop sample |
| q2 | input | 1 | Second (window-delayed) detector flip-flop sample |
| harmonic_ok | input | 1 | Harmonic check passed |
| code | output | CW | Delay control word for all delay blocks |
| therm | output | 2**FW-1 | Thermometer form of the fine field |
| locked | output | 1 | Lock reached |
| state | output | 2 | Current stage |

## Verification
The assertions assume that `q1`, `q2`, `upd` and `harmonic_ok` are already synchronous to `clk` and hold steady between edges. They also assume that `upd` may be held high on consecutive cycles. The bench drives every input at the falling edge. It produces detector pairs from a model of an ideal delay target compared with the current word, so the pair always corresponds to a consistent phase relation. On top of this, it injects invalid pairs and idle cycles at fixed intervals, and it moves the target past both ends of the range so that saturation is reached.

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl #(
  parameter int CW = 7,
  parameter int FW = 3,
  localparam int TW = (1 << FW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic          q1,
  input  logic          q2,
  input  logic          harmonic_ok,
  output logic [CW-1:0] code,
  output logic [TW-1:0] therm,
  output logic          locked,
  output logic [1:0]    state
);
  localparam int IW = (CW > 2) ? $clog2(CW) : 1;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] TOPC = {CW{1'b1}};

  typedef enum logic [1:0] {S_HARM = 2'd0, S_SRCH = 2'd1, S_LOCK = 2'd2, S_TRK = 2'd3} st_t;

  st_t           st_q;
  logic [CW-1:0] code_q;
  logic [CW-1:0] srch_nxt;
  logic [IW-1:0] bit_q;

  wire pd_up = !q1 && !q2;
  wire pd_dn = q1 && q2;
  wire pd_in = !q1 && q2;
  wire pd_ok = pd_up || pd_dn || pd_in;

  always_comb begin
    srch_nxt = code_q;
    if (pd_dn) srch_nxt[bit_q] = 1'b0;
    if (bit_q != '0) srch_nxt[bit_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_HARM;
      code_q <= '0;
      bit_q  <= '0;
    end else if (upd && pd_ok) begin
      case (st_q)
        S_HARM: if (harmonic_ok) begin
          st_q   <= S_SRCH;
          code_q <= ONE << (CW - 2);
          bit_q  <= IW'(CW - 2);
        end
        S_SRCH: begin
          code_q <= srch_nxt;
          if (bit_q == '0) st_q <= S_LOCK;
          else bit_q <= bit_q - 1'b1;
        end
        S_LOCK: st_q <= S_TRK;
        S_TRK: begin
          if (pd_up && code_q != TOPC) code_q <= code_q + 1'b1;
          else if (pd_dn && code_q != '0) code_q <= code_q - 1'b1;
        end
        default: st_q <= S_HARM;
      endcase
    end
  end

  assign code   = code_q;
  assign state  = st_q;
  assign locked = st_q[1];

  for (genvar i = 0; i < TW; i++) begin : g_therm
    assign therm[i] = code_q[FW-1:0] > FW'(i);
  end
endmodule

module dll_lock_ctrl_chk #(
  parameter int CW = 7,
  parameter int FW = 3,
  localparam int TW = (1 << FW) - 1
) (
  input logic          clk,
  input logic          rst,
  input logic          upd,
  input logic          q1,
  input logic          q2,
  input logic [CW-1:0] code,
  input logic [TW-1:0] therm,
  input logic          locked,
  input logic [1:0]    state
);
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (code == '0 && state == 2'd0));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(code) && $stable(state)));

  assert_invalid_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && q1 && !q2) |=> ($stable(code) && $stable(state)));

  assert_search_top_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1) |-> !code[CW-1]);

  assert_track_step_R7: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3 && $past(state) == 2'd3) |->
      (code == $past(code) || code == CW'($past(code) + 1'b1) || code == CW'($past(code) - 1'b1)));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3 && code == '1) |=> code != '0);

  assert_lock_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> state == 2'd2);

  assert_therm_count_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(therm) == int'(code[FW-1:0]));
endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .q1(q1), .q2(q2),
  .code(code), .therm(therm), .locked(locked), .state(state)
);

// File: tb/dll_lock_ctrl_bench.sv
module dll_lock_ctrl_bench;
  localparam int CW = 7;
  localparam int FW = 3;
  localparam int TW = (1 << FW) - 1;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst = 1, upd = 0, q1 = 0, q2 = 0, hok = 0;
  logic [CW-1:0] code;
  logic [TW-1:0] therm;
  logic locked;
  logic [1:0] state;

  int checks = 0, errors = 0;
  int m_st = 0, m_cd = 0, m_bit = 0;
  string ph = "R2";

  always #10 clk = ~clk;

  dll_lock_ctrl #(.CW(CW), .FW(FW)) u_dll_lock_ctrl (
    .clk(clk), .rst(rst), .upd(upd), .q1(q1), .q2(q2), .harmonic_ok(hok),
    .code(code), .therm(therm), .locked(locked), .state(state));

  // behavioural reference of the stage sequence
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cd = 0; m_bit = 0;
    end else if (upd && !(q1 && !q2)) begin
      if (m_st == 0) begin
        if (hok) begin m_st = 1; m_bit = CW - 2; m_cd = 2 ** (CW - 2); end
      end else if (m_st == 1) begin
        if (q1 && q2) m_cd = m_cd - 2 ** m_bit;
        if (m_bit == 0) m_st = 2;
        else begin m_bit = m_bit - 1; m_cd = m_cd + 2 ** m_bit; end
      end else if (m_st == 2) begin
        m_st = 3;
      end else begin
        if (!q1 && !q2 && m_cd < MAXC) m_cd = m_cd + 1;
        else if (q1 && q2 && m_cd > 0) m_cd = m_cd - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int fine, exp_t;
    fine = m_cd % (1 << FW);
    exp_t = 0;
    for (int i = 0; i < TW; i++) if (fine > i) exp_t = exp_t | (1 << i);
    chk(int'(state) == m_st, "R2", int'(state), m_st);
    chk(int'(code) == m_cd, tag, int'(code), m_cd);
    chk(int'(therm) == exp_t, "R10", int'(therm), exp_t);
    chk(locked == (m_st >= 2), "R9", int'(locked), int'(m_st >= 2));
  endtask

  task automatic cyc(input bit u, input bit a, input bit b, input bit h);
    string tag;
    upd = u; q1 = a; q2 = b; hok = h;
    tag = !u ? "R11" : ((a && !b) ? "R5" : ph);
    @(negedge clk);
    compare(rst ? "R1" : tag);
  endtask

  // ideal phase relation: code below target -> reference late (00)
  task automatic drive(input int tgt, input int n);
    for (int k = 0; k < n; k++) begin
      if (k % 5 == 3) cyc(1, 1, 0, 0);
      else if (k % 7 == 4) cyc(0, 0, 0, 0);
      else if (m_cd < tgt) cyc(1, 0, 0, 0);
      else if (m_cd > tgt) cyc(1, 1, 1, 0);
      else cyc(1, 0, 1, 0);
    end
  endtask

  task automatic run(input int tgt);
    ph = "R3";
    cyc(1, 0, 0, 0); cyc(1, 1, 1, 0); cyc(0, 0, 0, 1);
    chk(code == 0 && state == 0, "R3", int'(code), 0);
    cyc(1, 0, 0, 1);
    chk(int'(code) == 2 ** (CW - 2), "R3", int'(code), 2 ** (CW - 2));
    ph = "R4";
    for (int k = 0; k < 40 && m_st == 1; k++) drive(tgt, 1);
    chk(state == 2, "R4", int'(state), 2);
    ph = "R6";
    cyc(1, 1, 0, 0);
    chk(state == 2, "R5", int'(state), 2);
    cyc(1, 0, 0, 0);
    chk(state == 3 && int'(code) == m_cd, "R6", int'(state), 3);
  endtask

  initial begin
    repeat (2) cyc(0, 0, 0, 1);
    chk(code == 0 && state == 0 && !locked && therm == 0, "R1", int'(code), 0);
    rst = 0;
    run(37);
    chk(int'(code) == 37 || int'(code) == 36, "R4", int'(code), 37);
    ph = "R7"; drive(44, 20); drive(30, 30);
    ph = "R8"; drive(MAXC + 5, 180);
    chk(int'(code) == MAXC, "R8", int'(code), MAXC);
    cyc(1, 0, 0, 0);
    chk(int'(code) == MAXC, "R8", int'(code), MAXC);
    drive(-5, 200);
    chk(code == 0, "R8", int'(code), 0);
    cyc(1, 0, 0, 0);
    chk(code == 1, "R7", int'(code), 1);
    rst = 1; cyc(1, 0, 0, 1);
    chk(code == 0 && state == 0, "R1", int'(code), 0);
    rst = 0;
    run(5);
    ph = "R7"; drive(9, 20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule